// File: doc/BRIEF.md
# Grouped Interrupt Combiner with Per-Source Masking

The block takes a wide set of level-sensitive interrupt sources and folds them into groups of eight. Each group drives a single request line toward a downstream interrupt controller. The line is high whenever at least one of the group's sources is both asserted and enabled. Software manages the per-source enables through a word-addressed register port. Every 32-bit word covers four neighbouring groups, one byte lane per group.

Enables are never written directly. A set register turns bits on and a clear register turns bits off, so two agents that own different sources never need a read-modify-write. Software can read the raw input levels and the masked levels four groups at a time. Two summary words give the state of all group lines at once.

An instance can be configured as an external combiner. In that mode the groups from a configured limit upward ignore their inputs and stay quiet. An illegal write is dropped and produces a one-cycle error pulse.

Top module: `irq_combiner`

## Requirements
- R1: Source input n belongs to group n/8 at bit n%8. The raw status register (word index 2 of quad q, word address 4q+2) returns the registered input levels of groups 4q..4q+3, with group 4q+k in data byte k. A bit follows its input one clock after the input changes.
- R2: A write to word index 0 of quad q (enable-set) ORs each 1 bit of data byte k into the enable byte of group 4q+k. Bits written as 0 leave their enables as they were.
- R3: A write to word index 1 of quad q (enable-clear) clears the enable bit of group 4q+k for every 1 bit in data byte k. All other enable bits are unchanged.
- R4: Word index 3 of quad q returns, in byte k, the AND of the pending and enable bytes of group 4q+k.
- R5: Group output g is high exactly when its pending AND enable byte is nonzero. It is registered and reflects an input change or an enable write on the first rising clock edge after it.
- R6: Word addresses 0x100 and 0x101 (byte offsets 0x400 and 0x404) return the group outputs. Bit i of the word at 0x100 is group i, and bit i of the word at 0x101 is group 32+i.
- R7: Reads of the enable-set and enable-clear registers return zero.
- R8: A write is illegal when it targets word index 2 or 3, any address with word-address bit 8 set, or a quad that lies beyond the last group. An illegal write changes no enable and raises err_o for exactly the one cycle after it. A legal write leaves err_o low.
- R9: After reset, all enables and pending bits are zero, all group outputs are low and err_o is low.
- R10: With EXTERNAL set, groups numbered EXT_GROUP_LIMIT or higher ignore their inputs. Their raw status reads as zero and their outputs stay low even when the sources are high and enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_GROUPS*8 | Level-sensitive interrupt sources |
| req_valid | input | 1 | Register access strobe for this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_waddr | input | WA_W | Word address (byte offset divided by 4) |
| req_wdata | input | 32 | Write data, one byte lane per group of the quad |
| rdata_o | output | 32 | Read data for the current read access (combinational) |
| grp_irq_o | output | NUM_GROUPS | Registered request line per group |
| err_o | output | 1 | One-cycle pulse after an illegal write |

## Verification
The bench enables one bit of a group and then sets a second bit. A design that overwrote the enables instead of ORing into them would drop the first bit and lower the masked status. Clearing one bit of a group that has two enabled bits must keep the line up, and an enable-clear that also touched zero-data bits would lower it. A bad lane decode would put a source in the wrong byte of raw status or raise the wrong summary bit. A status register that acted on writes would change the masked readback, and an output that was combinational or one cycle too late would fail the same-cycle and next-cycle samples. A second instance in external mode shows that a high, enabled source in an ignored group never reaches that group's output.

// File: rtl/irq_comb_pkg.sv
package irq_comb_pkg;
   localparam int GRP_W = 8;
   localparam int LANES = 4;

   typedef enum logic [1:0] {
      IDX_EN_SET = 2'd0,
      IDX_EN_CLR = 2'd1,
      IDX_RAW    = 2'd2,
      IDX_MASKED = 2'd3
   } reg_idx_e;

   typedef struct packed {
      logic     set_wr;
      logic     clr_wr;
      logic     illegal_wr;
      logic     in_quad;
      logic     in_sum;
      reg_idx_e idx;
   } dec_t;
endpackage

// File: rtl/irq_comb_decode.sv
module irq_comb_decode
   import irq_comb_pkg::*;
#(
   parameter int WA_W      = 9,
   parameter int NUM_QUADS = 16,
   parameter int SUM_WORDS = 2
) (
   input  logic            req_valid,
   input  logic            req_write,
   input  logic [WA_W-1:0] req_waddr,
   output dec_t            dec_o,
   output logic [WA_W-4:0] quad_o,
   output logic [WA_W-2:0] sum_word_o
);
   logic wr;

   always_comb begin
      quad_o        = req_waddr[WA_W-2:2];
      sum_word_o    = req_waddr[WA_W-2:0];
      dec_o.idx     = reg_idx_e'(req_waddr[1:0]);
      dec_o.in_quad = !req_waddr[WA_W-1] && (32'(quad_o) < NUM_QUADS);
      dec_o.in_sum  = req_waddr[WA_W-1] && (32'(sum_word_o) < SUM_WORDS);
      wr            = req_valid && req_write;
      dec_o.set_wr  = wr && dec_o.in_quad && (dec_o.idx == IDX_EN_SET);
      dec_o.clr_wr  = wr && dec_o.in_quad && (dec_o.idx == IDX_EN_CLR);
      dec_o.illegal_wr = wr && !(dec_o.in_quad &&
                         (dec_o.idx == IDX_EN_SET || dec_o.idx == IDX_EN_CLR));
   end
endmodule

// File: rtl/irq_comb_group.sv
module irq_comb_group
   import irq_comb_pkg::*;
#(
   parameter bit IGNORE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [GRP_W-1:0] src_i,
   input  logic             set_we,
   input  logic             clr_we,
   input  logic [GRP_W-1:0] wbyte_i,
   output logic [GRP_W-1:0] pend_o,
   output logic [GRP_W-1:0] en_o,
   output logic             irq_o
);
   logic [GRP_W-1:0] src_eff;
   logic [GRP_W-1:0] en_nxt;

   generate
      if (IGNORE) begin : g_off
         logic unused_src;
         assign unused_src = ^src_i;
         assign src_eff    = '0;
      end else begin : g_on
         assign src_eff = src_i;
      end
   endgenerate

   always_comb begin
      en_nxt = en_o;
      if (set_we)      en_nxt = en_o | wbyte_i;
      else if (clr_we) en_nxt = en_o & ~wbyte_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_o <= '0;
         en_o   <= '0;
         irq_o  <= 1'b0;
      end else begin
         pend_o <= src_eff;
         en_o   <= en_nxt;
         irq_o  <= |(src_eff & en_nxt);
      end
   end
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
   import irq_comb_pkg::*;
#(
   parameter int NUM_GROUPS      = 64,
   parameter bit EXTERNAL        = 1'b0,
   parameter int EXT_GROUP_LIMIT = 16,
   parameter int WA_W            = 9
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_GROUPS*GRP_W-1:0] src_i,
   input  logic                        req_valid,
   input  logic                        req_write,
   input  logic [WA_W-1:0]             req_waddr,
   input  logic [31:0]                 req_wdata,
   output logic [31:0]                 rdata_o,
   output logic [NUM_GROUPS-1:0]       grp_irq_o,
   output logic                        err_o
);
   localparam int NUM_QUADS = NUM_GROUPS / LANES;
   localparam int SUM_WORDS = NUM_GROUPS / 32;
   localparam int LIVE_GRPS = EXTERNAL ? EXT_GROUP_LIMIT : NUM_GROUPS;

   generate
      if (NUM_GROUPS % 32 != 0 || NUM_GROUPS < 32)
         $error("NUM_GROUPS must be a nonzero multiple of 32");
      if (NUM_QUADS > 2 ** (WA_W - 3))
         $error("WA_W too small for NUM_GROUPS");
      if (EXTERNAL && (EXT_GROUP_LIMIT < 0 || EXT_GROUP_LIMIT > NUM_GROUPS))
         $error("EXT_GROUP_LIMIT out of range");
   endgenerate

   dec_t            dec;
   logic [WA_W-4:0] quad;
   logic [WA_W-2:0] sum_word;
   logic [GRP_W-1:0] pend [NUM_GROUPS];
   logic [GRP_W-1:0] en   [NUM_GROUPS];

   irq_comb_decode #(
      .WA_W(WA_W), .NUM_QUADS(NUM_QUADS), .SUM_WORDS(SUM_WORDS)
   ) dec_i (
      .req_valid (req_valid),
      .req_write (req_write),
      .req_waddr (req_waddr),
      .dec_o     (dec),
      .quad_o    (quad),
      .sum_word_o(sum_word)
   );

   generate
      for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
         irq_comb_group #(.IGNORE(g >= LIVE_GRPS)) grp_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_i  (src_i[g*GRP_W +: GRP_W]),
            .set_we (dec.set_wr && (32'(quad) == g / LANES)),
            .clr_we (dec.clr_wr && (32'(quad) == g / LANES)),
            .wbyte_i(req_wdata[(g % LANES)*GRP_W +: GRP_W]),
            .pend_o (pend[g]),
            .en_o   (en[g]),
            .irq_o  (grp_irq_o[g])
         );
      end
   endgenerate

   always_comb begin
      int gi;
      gi      = 0;
      rdata_o = '0;
      if (req_valid && !req_write) begin
         if (dec.in_quad) begin
            for (int k = 0; k < LANES; k++) begin
               gi = 32'(quad) * LANES + k;
               case (dec.idx)
                  IDX_RAW:    rdata_o[k*GRP_W +: GRP_W] = pend[gi];
                  IDX_MASKED: rdata_o[k*GRP_W +: GRP_W] = pend[gi] & en[gi];
                  default:    rdata_o[k*GRP_W +: GRP_W] = '0;
               endcase
            end
         end else if (dec.in_sum) begin
            rdata_o = grp_irq_o[32'(sum_word)*32 +: 32];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_o <= 1'b0;
      else        err_o <= dec.illegal_wr;
   end
endmodule

// File: rtl/irq_combiner_chk.sv
module irq_combiner_chk #(
   parameter int NUM_GROUPS      = 64,
   parameter bit EXTERNAL        = 1'b0,
   parameter int EXT_GROUP_LIMIT = 16,
   parameter int WA_W            = 9
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [NUM_GROUPS*8-1:0] src_i,
   input logic                    req_valid,
   input logic                    req_write,
   input logic [WA_W-1:0]         req_waddr,
   input logic [31:0]             rdata_o,
   input logic [NUM_GROUPS-1:0]   grp_irq_o,
   input logic                    err_o
);
   // R8
   err_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> $past(req_valid && req_write));

   // R9
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (grp_irq_o == '0 && !err_o));

   // R5
   no_src_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(src_i == '0) |-> (grp_irq_o == '0));

   // R7
   rd_ctrl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && !req_waddr[WA_W-1] && !req_waddr[1])
      |-> (rdata_o == '0));

   // R6
   summary_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_waddr == {1'b1, {(WA_W-1){1'b0}}})
      |-> (rdata_o == grp_irq_o[31:0]));

   generate
      if (EXTERNAL && EXT_GROUP_LIMIT < NUM_GROUPS) begin : g_ext
         // R10
         ext_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grp_irq_o[NUM_GROUPS-1:EXT_GROUP_LIMIT] == '0);
      end
   endgenerate
endmodule

bind irq_combiner irq_combiner_chk #(
   .NUM_GROUPS(NUM_GROUPS), .EXTERNAL(EXTERNAL),
   .EXT_GROUP_LIMIT(EXT_GROUP_LIMIT), .WA_W(WA_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .src_i(src_i), .req_valid(req_valid),
   .req_write(req_write), .req_waddr(req_waddr), .rdata_o(rdata_o),
   .grp_irq_o(grp_irq_o), .err_o(err_o)
);

// File: tb/irq_combiner_tb_top.sv
module irq_combiner_tb_top;
   localparam int NG = 64;
   localparam int WA = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NG*8-1:0] src = '0;
   logic [NG*8-1:0] ext_src = '0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [WA-1:0] req_waddr = '0;
   logic [31:0]   req_wdata = '0;
   logic [31:0]   rdata, ext_rdata;
   logic [NG-1:0] irq, ext_irq;
   logic          err, ext_err;
   int            checks = 0;
   int            errors = 0;
   bit            done = 1'b0;

   always #10 clk = ~clk;

   irq_combiner #(.NUM_GROUPS(NG), .WA_W(WA)) dut_i (
      .clk(clk), .rst_n(rst_n), .src_i(src), .req_valid(req_valid),
      .req_write(req_write), .req_waddr(req_waddr), .req_wdata(req_wdata),
      .rdata_o(rdata), .grp_irq_o(irq), .err_o(err));

   irq_combiner #(.NUM_GROUPS(NG), .EXTERNAL(1'b1), .EXT_GROUP_LIMIT(16),
                  .WA_W(WA)) ext_i (
      .clk(clk), .rst_n(rst_n), .src_i(ext_src), .req_valid(req_valid),
      .req_write(req_write), .req_waddr(req_waddr), .req_wdata(req_wdata),
      .rdata_o(ext_rdata), .grp_irq_o(ext_irq), .err_o(ext_err));

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(logic [WA-1:0] a, logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_waddr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic bus_rd(logic [WA-1:0] a, output logic [31:0] d,
                         output logic [31:0] e);
      req_valid = 1'b1; req_write = 1'b0; req_waddr = a;
      #1;
      d = rdata; e = ext_rdata;
      req_valid = 1'b0;
   endtask

   task automatic set_src(int n, logic v);
      @(negedge clk);
      src[n] = v;
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d, e;
      chk("R9 irq", 64'(irq), 0);
      chk("R9 err", 64'(err), 0);
      bus_rd(9'h006, d, e);
      chk("R9 raw", 64'(d), 0);
      bus_rd(9'h100, d, e);
      chk("R9 summary", 64'(d), 0);
   endtask

   task automatic t_mapping();
      logic [31:0] d, e;
      set_src(43, 1'b1);
      bus_rd(9'h006, d, e);
      chk("R1 raw lane", 64'(d), 64'h0000_0800);
      chk("R5 disabled stays low", 64'(irq[5]), 0);
      set_src(43, 1'b0);
      bus_rd(9'h006, d, e);
      chk("R1 raw follows low", 64'(d), 0);
   endtask

   task automatic t_set();
      logic [31:0] d, e;
      set_src(43, 1'b1);
      bus_wr(9'h004, 32'h0000_0800);
      chk("R5 irq after enable", 64'(irq[5]), 1);
      bus_rd(9'h007, d, e);
      chk("R4 masked", 64'(d), 64'h0000_0800);
      bus_wr(9'h004, 32'h0000_0100);
      bus_rd(9'h007, d, e);
      chk("R2 set is OR", 64'(d), 64'h0000_0800);
      @(negedge clk);
      src[43] = 1'b0;
      #1;
      chk("R5 not before edge", 64'(irq[5]), 1);
      @(negedge clk);
      chk("R5 low one clock later", 64'(irq[5]), 0);
   endtask

   task automatic t_clear();
      logic [31:0] d, e;
      set_src(43, 1'b1);
      bus_wr(9'h005, 32'h0000_0100);
      chk("R3 other bit kept", 64'(irq[5]), 1);
      bus_wr(9'h005, 32'h0000_0800);
      chk("R3 cleared irq", 64'(irq[5]), 0);
      bus_rd(9'h007, d, e);
      chk("R3 masked zero", 64'(d), 0);
      bus_rd(9'h006, d, e);
      chk("R1 raw still set", 64'(d), 64'h0000_0800);
   endtask

   task automatic t_summary();
      logic [31:0] d, e;
      bus_wr(9'h028, 32'h0000_0001);
      bus_wr(9'h000, 32'h0000_0080);
      @(negedge clk);
      src[320] = 1'b1; src[7] = 1'b1;
      @(negedge clk);
      bus_rd(9'h101, d, e);
      chk("R6 summary high word", 64'(d), 64'h0000_0100);
      bus_rd(9'h100, d, e);
      chk("R6 summary low word", 64'(d), 64'h0000_0001);
   endtask

   task automatic t_rdzero();
      logic [31:0] d, e;
      bus_rd(9'h028, d, e);
      chk("R7 set reads zero", 64'(d), 0);
      bus_rd(9'h029, d, e);
      chk("R7 clear reads zero", 64'(d), 0);
   endtask

   task automatic t_illegal();
      logic [31:0] d, e;
      bus_wr(9'h02A, 32'hFFFF_FFFF);
      chk("R8 err on status write", 64'(err), 1);
      @(negedge clk);
      chk("R8 err single cycle", 64'(err), 0);
      bus_rd(9'h02B, d, e);
      chk("R8 status write not applied", 64'(d), 64'h0000_0001);
      bus_wr(9'h02B, 32'hFFFF_FFFF);
      chk("R8 err on masked write", 64'(err), 1);
      bus_wr(9'h100, 32'hFFFF_FFFF);
      chk("R8 err on summary write", 64'(err), 1);
      bus_wr(9'h040, 32'h0000_00FF);
      chk("R8 err past last quad", 64'(err), 1);
      bus_wr(9'h000, 32'h0000_0000);
      chk("R8 legal write no err", 64'(err), 0);
      bus_rd(9'h003, d, e);
      chk("R8 quad 0 masked kept", 64'(d), 64'h0000_0080);
   endtask

   task automatic t_external();
      logic [31:0] d, e;
      bus_wr(9'h000, 32'h0000_0001);
      bus_wr(9'h010, 32'h0000_0001);
      @(negedge clk);
      ext_src[0] = 1'b1; ext_src[128] = 1'b1;
      @(negedge clk);
      chk("R10 live group fires", 64'(ext_irq[0]), 1);
      chk("R10 ignored group low", 64'(ext_irq[16]), 0);
      bus_rd(9'h012, d, e);
      chk("R10 ignored raw zero", 64'(e), 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mapping();
      t_set();
      t_clear();
      t_summary();
      t_rdzero();
      t_illegal();
      t_external();
      finish_run();
   end

   initial begin
      #(20 * 100000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule